// File: doc/BRIEF.md
# Read-Before-Write Memory Access Sequencer

This block sits between the execution unit of a small 16-bit processor core and a zero-wait-state, 16-bit wide memory port. The execution unit hands it one operand access at a time: an instruction fetch, an operand read, or a destination store. Each request carries a byte/word flag and a flag telling whether the current opcode exists in a byte form. The sequencer turns each request into the bus cycles it needs and returns read data to the execution unit.

A destination store for an opcode that has a byte form always reads the target word first and then writes it, even when the store is a full word. For byte stores the new byte is merged into the word just read, so the other half of the word is preserved. Opcodes without a byte form, such as a load-immediate, write the destination directly with no read. A per-instruction access counter, restarted by every instruction fetch, lets a bench confirm the bus-cycle total of each instruction: four for a memory-to-memory move, three for a load-immediate.

Top module: `mem_rmw_sequencer`

## Requirements
- R1: After reset, req_ready is 1, mem_rd, mem_wr and rsp_valid are 0, and acc_count is 0.
- R2: A request with req_kind 2'b00 (instruction fetch) or 2'b01 (operand read; 2'b11 behaves the same) produces exactly one mem_rd cycle in the cycle after acceptance, at the request address with bit 0 cleared; the word read is presented on rsp_data with rsp_valid high in the following cycle.
- R3: A request with req_kind 2'b10 (destination store) and req_byte_form 1 produces a mem_rd cycle followed directly by a mem_wr cycle to the same word, whether req_byte is 0 or 1; a word store writes req_wdata unchanged.
- R4: A destination store with req_byte_form 0 produces a single mem_wr cycle and no read; req_byte is ignored and the whole req_wdata word is written.
- R5: A byte store (req_byte 1, req_byte_form 1) to an even address writes req_wdata[7:0] into bits [15:8] of the word and keeps bits [7:0] from the word read.
- R6: A byte store to an odd address writes req_wdata[7:0] into bits [7:0] and keeps bits [15:8] from the word read.
- R7: The word read by a read-before-write store is returned on rsp_data with rsp_valid high, in the cycle of the write.
- R8: req_ready is 0 in every cycle in which a bus cycle is issued and returns to 1 only after the last bus cycle of the request; no bus cycle is issued while req_ready is 1.
- R9: acc_count becomes 1 on the bus cycle of an instruction fetch and rises by one on every other bus cycle, saturating at its maximum (15 by default); a move between memory operands totals 4 and a load-immediate totals 3.
- R10: mem_rd and mem_wr are never high together, and mem_addr bit 0 is 0 whenever either is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_kind | input | 2 | 00 fetch, 01 operand read, 10 destination store |
| req_addr | input | AW (16) | Byte address of the access |
| req_byte | input | 1 | Byte-sized store |
| req_byte_form | input | 1 | Current opcode has a byte form |
| req_wdata | input | DW (16) | Store data; a byte store uses bits [7:0] |
| rsp_valid | output | 1 | rsp_data holds a word read from memory |
| rsp_data | output | DW (16) | Word read by the last read cycle |
| mem_addr | output | AW (16) | Word-aligned bus address |
| mem_rd | output | 1 | Bus read cycle |
| mem_wr | output | 1 | Bus write cycle |
| mem_wdata | output | DW (16) | Bus write data |
| mem_rdata | input | DW (16) | Bus read data, valid in the read cycle |
| acc_count | output | CNT_W (4) | Bus cycles since the last instruction fetch |

## Verification
The bench plays whole instructions: a word move and byte moves to even and odd addresses with a byte-form opcode, a load-immediate and a byte-flagged store without a byte form, an immediate instruction that stores with a byte form, and a long run of operand reads after one fetch. The word move separates the read-before-write rule from a read only on byte stores, while the byte-flagged store without a byte form shows the byte flag alone never triggers a read or a merge. Even and odd byte stores tell apart the two merge halves, and the long run shows the counter stops at its maximum instead of wrapping.

// File: rtl/mem_rmw_sequencer.sv
module mem_rmw_sequencer #(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_kind,
  input  logic [AW-1:0]    req_addr,
  input  logic             req_byte,
  input  logic             req_byte_form,
  input  logic [DW-1:0]    req_wdata,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_data,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  output logic [CNT_W-1:0] acc_count
);
  localparam int HB = DW / 2;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [1:0] K_FETCH = 2'b00;
  localparam logic [1:0] K_STORE = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  st_t           st;
  logic [1:0]    kind_q;
  logic [AW-1:0] addr_q;
  logic          bsel_q;
  logic [DW-1:0] wd_q;
  logic [DW-1:0] old_q;

  wire take = req_valid && req_ready;

  assign req_ready = (st == S_IDLE);
  assign mem_rd    = (st == S_RD);
  assign mem_wr    = (st == S_WR);
  assign mem_addr  = {addr_q[AW-1:1], 1'b0};

  always_comb begin
    if (!bsel_q)
      mem_wdata = wd_q;
    else if (addr_q[0])
      mem_wdata = {old_q[DW-1:HB], wd_q[HB-1:0]};
    else
      mem_wdata = {wd_q[HB-1:0], old_q[HB-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      kind_q    <= K_FETCH;
      addr_q    <= '0;
      bsel_q    <= 1'b0;
      wd_q      <= '0;
      old_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (take) begin
          kind_q <= req_kind;
          addr_q <= req_addr;
          bsel_q <= req_byte && req_byte_form;
          wd_q   <= req_wdata;
          st     <= (req_kind == K_STORE && !req_byte_form) ? S_WR : S_RD;
        end
        S_RD: begin
          old_q     <= mem_rdata;
          rsp_data  <= mem_rdata;
          rsp_valid <= 1'b1;
          st        <= (kind_q == K_STORE) ? S_WR : S_IDLE;
        end
        S_WR:    st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      acc_count <= '0;
    else if (mem_rd || mem_wr) begin
      if (kind_q == K_FETCH)
        acc_count <= {{(CNT_W-1){1'b0}}, 1'b1};
      else if (acc_count != CNT_MAX)
        acc_count <= acc_count + 1'b1;
    end
  end
endmodule

// File: rtl/mem_rmw_sequencer_chk.sv
module mem_rmw_sequencer_chk #(
  parameter int AW    = 16,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic [AW-1:0]    mem_addr,
  input logic             mem_rd,
  input logic             mem_wr,
  input logic [CNT_W-1:0] acc_count
);
  AST_BUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R10
  AST_ADDR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> !mem_addr[0]); // R10
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> !req_ready); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !(mem_rd || mem_wr)); // R8
  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(mem_rd)); // R2
  AST_RMW_SAME_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && $past(mem_rd)) |-> (mem_addr == $past(mem_addr))); // R3
  AST_CNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |=> (acc_count != '0)); // R9
endmodule

bind mem_rmw_sequencer mem_rmw_sequencer_chk #(.AW(AW), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .acc_count(acc_count)
);

// File: tb/test_mem_rmw_sequencer.sv
module test_mem_rmw_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = 2'b00;
  logic [15:0] req_addr = '0;
  logic        req_byte = 1'b0;
  logic        req_byte_form = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic [15:0] mem_addr;
  logic        mem_rd;
  logic        mem_wr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic [3:0]  acc_count;

  int total = 0;
  int bad = 0;

  logic [15:0] mem    [0:15];
  logic [15:0] shadow [0:15];
  logic [32:0] bus_q [$];
  string       bus_tag [$];
  logic [15:0] rsp_q [$];
  string       rsp_tag [$];

  always #5 clk = ~clk;

  mem_rmw_sequencer i_mem_rmw_sequencer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_byte(req_byte),
    .req_byte_form(req_byte_form), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .acc_count(acc_count)
  );

  assign mem_rdata = mem[mem_addr[4:1]];
  always @(posedge clk) if (mem_wr) mem[mem_addr[4:1]] <= mem_wdata;

  task automatic chk(input bit ok, input string tag, input logic [32:0] act, input logic [32:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (mem_rd || mem_wr) begin
      logic [32:0] got;
      got = {mem_wr, mem_addr, mem_wr ? mem_wdata : mem_rdata};
      chk(!req_ready, "R8", {32'd0, req_ready}, 33'd0);
      if (bus_q.size() == 0) chk(1'b0, "R2 unexpected bus cycle", got, '0);
      else begin
        logic [32:0] e;
        string t;
        e = bus_q.pop_front();
        t = bus_tag.pop_front();
        chk(got == e, t, got, e);
      end
    end
    if (rsp_valid) begin
      if (rsp_q.size() == 0) chk(1'b0, "R2 unexpected response", {17'd0, rsp_data}, '0);
      else begin
        logic [15:0] e;
        string t;
        e = rsp_q.pop_front();
        t = rsp_tag.pop_front();
        chk(rsp_data == e, t, {17'd0, rsp_data}, {17'd0, e});
      end
    end
  end

  task automatic op(input logic [1:0] kind, input logic [15:0] addr, input bit bt,
                    input bit bf, input logic [15:0] wd, input string wtag);
    logic [15:0] al;
    logic [15:0] w;
    logic [15:0] nw;
    al = {addr[15:1], 1'b0};
    w  = shadow[addr[4:1]];
    if (kind != 2'b10) begin
      bus_q.push_back({1'b0, al, w}); bus_tag.push_back("R2");
      rsp_q.push_back(w);             rsp_tag.push_back("R2");
    end else begin
      nw = wd;
      if (bf) begin
        bus_q.push_back({1'b0, al, w}); bus_tag.push_back("R3");
        rsp_q.push_back(w);             rsp_tag.push_back("R7");
        if (bt) nw = addr[0] ? {w[15:8], wd[7:0]} : {wd[7:0], w[7:0]};
      end
      bus_q.push_back({1'b1, al, nw}); bus_tag.push_back(wtag);
      shadow[addr[4:1]] = nw;
    end
    req_valid = 1'b1; req_kind = kind; req_addr = addr;
    req_byte = bt; req_byte_form = bf; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
  endtask

  task automatic count_is(input logic [3:0] e, input string tag);
    chk(acc_count == e, tag, {29'd0, acc_count}, {29'd0, e});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i] = 16'hA000 + 16'(i) * 16'h0111;
      shadow[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready", {32'd0, req_ready}, 33'd1);
    chk(!mem_rd && !mem_wr, "R1 bus idle", {31'd0, mem_rd, mem_wr}, 33'd0);
    chk(!rsp_valid, "R1 rsp", {32'd0, rsp_valid}, 33'd0);
    count_is(4'd0, "R1 count");

    // word move with byte form: fetch, source, dest read, dest write (R3, R9)
    op(2'b00, 16'h0000, 0, 1, '0, "R3");
    op(2'b01, 16'h0010, 0, 1, '0, "R3");
    op(2'b10, 16'h0014, 0, 1, 16'h5AA5, "R3");
    count_is(4'd4, "R9 move total");

    // byte move to even address (R5)
    op(2'b00, 16'h0002, 0, 1, '0, "R5");
    op(2'b01, 16'h0012, 1, 1, '0, "R5");
    op(2'b10, 16'h0016, 1, 1, 16'hFF3C, "R5");
    count_is(4'd4, "R9 byte move total");

    // byte move to odd address (R6)
    op(2'b00, 16'h0004, 0, 1, '0, "R6");
    op(2'b01, 16'h0013, 1, 1, '0, "R6");
    op(2'b10, 16'h0017, 1, 1, 16'h00C7, "R6");
    count_is(4'd4, "R9 odd byte move total");

    // load immediate: no byte form, no destination read (R4, R9)
    op(2'b00, 16'h0006, 0, 0, '0, "R4");
    op(2'b01, 16'h0008, 0, 0, '0, "R4");
    op(2'b10, 16'h0018, 0, 0, 16'h1357, "R4");
    count_is(4'd3, "R9 load-immediate total");

    // byte flag without byte form is ignored: full word written (R4)
    op(2'b00, 16'h000A, 0, 0, '0, "R4");
    op(2'b10, 16'h0019, 1, 0, 16'h1234, "R4");
    count_is(4'd2, "R9 direct store total");

    // immediate with destination operand, byte form (R3)
    op(2'b00, 16'h000C, 0, 1, '0, "R3");
    op(2'b11, 16'h000E, 0, 1, '0, "R3");
    op(2'b10, 16'h001E, 0, 1, 16'h0F0F, "R3");
    count_is(4'd4, "R9 immediate total");

    // counter saturation (R9)
    op(2'b00, 16'h0000, 0, 1, '0, "R9");
    for (int i = 0; i < 20; i++) op(2'b01, 16'(2 * (i % 16)), 0, 1, '0, "R9");
    count_is(4'd15, "R9 saturation");

    repeat (2) @(negedge clk);
    chk(bus_q.size() == 0, "R8 pending bus cycles", 33'(bus_q.size()), 33'd0);
    chk(rsp_q.size() == 0, "R2 pending responses", 33'(rsp_q.size()), 33'd0);
    for (int i = 0; i < 16; i++)
      chk(mem[i] == shadow[i], "R5 R6 memory image", {17'd0, mem[i]}, {17'd0, shadow[i]});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule